// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block holds the interrupt bookkeeping of an SD host controller: a 32-bit raw event word, a 32-bit enable mask, a card status word and an internal-DMA status word. It drives one level-sensitive interrupt line toward the system interrupt controller. The command engine, the data path and the card-detect logic feed it single-cycle set pulses. Software reaches every register through a small 32-bit register port with separate read and write strobes.

Raw bits are cleared by writing ones. The same clear is accepted at two addresses: the raw view and the masked view. A global enable bit in the control word gates the interrupt line. Card insertion and removal are mutually exclusive events. Each sets its own raw bit, drops the opposite raw bit, and updates a card-present flag. Register selects (3-bit word index on `reg_addr`): 0 control, 1 mask, 2 masked status (read = raw AND mask), 3 raw status, 4 card status, 5 DMA status; 6 and 7 are unmapped.

Top module: `sdh_irq_status_unit`

## Requirements
- R1: After reset, control reads 0x0000_0300, mask 0, masked and raw status 0, card status 0x0000_0100, DMA status 0, and `irq_o` is low.
- R2: A read of select 2 returns the raw status word ANDed with the mask word.
- R3: `irq_o` is a register. One cycle after any state change, it equals (control bit 4) AND (OR-reduction of raw AND mask). When control bit 4 is 0, it is low.
- R4: A write to select 2 or select 3 clears each raw bit whose write-data bit is 1. All other raw bits are left unchanged.
- R5: A `card_insert` pulse, without `card_remove`, has three effects. It sets raw bit 30. It clears raw bit 31. It sets card-status bit 8 (card present).
- R6: A `card_remove` pulse has three effects. It sets raw bit 31. It clears raw bit 30. It clears card-status bit 8. If both pulses arrive in one cycle, removal takes effect and insertion is dropped.
- R7: A write to select 4 clears each card-status bit written as 1. Bits written as 0 keep their value.
- R8: A write to select 5 clears only DMA-status bits [9:0] that are written as 1. Bits [31:10] are never cleared by a write. A `dma_set` bit sets the matching DMA-status bit.
- R9: A write to select 0 stores all bits except [2:0], which always read as 0.
- R10: If a hardware set and a software clear reach the same bit in one cycle, the bit ends up set. This applies to raw, card-present and DMA bits.
- R11: `reg_rdata` is 0 when `reg_rd_en` is low. It is also 0 for selects 6 and 7. Writes to selects 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select (word index) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from current state |
| stat_set | input | 32 | Per-bit set pulses into raw status |
| card_insert | input | 1 | Card inserted pulse |
| card_remove | input | 1 | Card removed pulse |
| dma_set | input | 32 | Per-bit set pulses into DMA status |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The assertions assume every event input is a single-cycle pulse that is sampled on the clock. They also assume that all inputs are driven low while reset is active, since several properties compare the first cycle after reset with the reset cycle. The bench drives every input half a period away from the rising edge and forces all inputs to zero during reset. Random event words are built by ANDing several random values, so most cycles see only a few bits set. Insert and remove pulses are kept rare but may coincide, to reach the tie rule.

// File: rtl/sdh_irq_pkg.sv
// Package: shared constants and register selects for the SD host
// interrupt status unit. Assumes a 32-bit register word.
package sdh_irq_pkg;
    localparam int unsigned REG_W        = 32;
    localparam int unsigned SEL_W        = 3;
    localparam int unsigned CARD_IN_BIT  = 30;
    localparam int unsigned CARD_OUT_BIT = 31;
    localparam int unsigned PRESENT_BIT  = 8;
    localparam int unsigned IRQ_EN_BIT   = 4;
    localparam int unsigned NOSTORE_W    = 3;
    localparam logic [REG_W-1:0] CTRL_RST = 32'h0000_0300;
    localparam logic [REG_W-1:0] CARD_RST = 32'h0000_0100;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_MASK   = 3'd1,
        SEL_MASKED = 3'd2,
        SEL_RAW    = 3'd3,
        SEL_CARD   = 3'd4,
        SEL_DMA    = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/sdh_raw_status.sv
// Module: raw interrupt status word built from one cell per bit.
// A bit is set by a hardware pulse. It is cleared by software or by a
// hardware clear. A set in the same cycle as a clear wins.
// Assumes hw_set and hw_clr never name the same bit, unless the set
// is meant to win.
module sdh_raw_status #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] raw_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit sticky flag with set priority.
        always_ff @(posedge clk) begin
            if (!rst_n) raw_q[i] <= 1'b0;
            else        raw_q[i] <= hw_set[i] | (raw_q[i] & ~sw_clr[i] & ~hw_clr[i]);
        end
    end

    // R10: every bit pulsed by hardware is set in the following cycle.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((raw_q & $past(hw_set)) == $past(hw_set)));

    // R4: a software clear with no competing set leaves those bits low.
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sw_clr) && ((sw_clr & hw_set) == '0)) |=> ((raw_q & $past(sw_clr)) == '0));
endmodule

// File: rtl/sdh_card_dma_status.sv
// Module: card status word and internal-DMA status word. It also turns
// the card insert and remove pulses into set and clear vectors for the
// raw status word. Assumes the pulses last one cycle. Removal wins a tie.
module sdh_card_dma_status
    import sdh_irq_pkg::*;
#(
    parameter int unsigned DMA_W1C_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_insert,
    input  logic             card_remove,
    input  logic             wr_card,
    input  logic             wr_dma,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] dma_set,
    output logic [REG_W-1:0] card_q,
    output logic [REG_W-1:0] dma_q,
    output logic [REG_W-1:0] raw_set,
    output logic [REG_W-1:0] raw_clr
);
    localparam logic [REG_W-1:0] DMA_W1C_MASK = (REG_W)'((64'd1 << DMA_W1C_W) - 64'd1);

    logic ins_eff;
    logic [REG_W-1:0] card_sw_clr;
    logic [REG_W-1:0] dma_sw_clr;

    // Resolve a simultaneous insert and remove in favour of removal.
    always_comb begin
        ins_eff     = card_insert & ~card_remove;
        raw_set     = '0;
        raw_clr     = '0;
        raw_set[CARD_IN_BIT]  = ins_eff;
        raw_set[CARD_OUT_BIT] = card_remove;
        raw_clr[CARD_IN_BIT]  = card_remove;
        raw_clr[CARD_OUT_BIT] = ins_eff;
        card_sw_clr = wr_card ? wdata : '0;
        dma_sw_clr  = wr_dma ? (wdata & DMA_W1C_MASK) : '0;
    end

    // Card status: software clears, then the card events override bit 8.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_q <= CARD_RST;
        end else begin
            card_q <= card_q & ~card_sw_clr;
            if (card_remove)  card_q[PRESENT_BIT] <= 1'b0;
            else if (ins_eff) card_q[PRESENT_BIT] <= 1'b1;
        end
    end

    // DMA status: set pulses win over the partial write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_q <= '0;
        else        dma_q <= (dma_q & ~dma_sw_clr) | dma_set;
    end

    a_r5_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (card_insert && !card_remove) |=> card_q[PRESENT_BIT]);

    a_r6_remove: assert property (@(posedge clk) disable iff (!rst_n)
        card_remove |=> !card_q[PRESENT_BIT]);

    // R8: bits above the clearable field never fall.
    a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(dma_q) & ~DMA_W1C_MASK) & ~dma_q) == '0));
endmodule

// File: rtl/sdh_irq_gate.sv
// Module: control word, mask word and the registered interrupt line.
// Control bits [2:0] are never stored. The line follows the state one
// cycle late. Assumes the write strobes are already decoded.
module sdh_irq_gate
    import sdh_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_mask,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] raw_i,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] masked_o,
    output logic             irq_o
);
    localparam logic [REG_W-1:0] KEEP = ~((REG_W)'((1 << NOSTORE_W) - 1));

    // Masked view of the raw word.
    always_comb masked_o = raw_i & mask_q;

    // Control and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata & KEEP;
            if (wr_mask) mask_q <= wdata;
        end
    end

    // Registered, globally gated interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= ctrl_q[IRQ_EN_BIT] & (|masked_o);
    end

    a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[IRQ_EN_BIT] |=> !irq_o);

    a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(raw_i & mask_q)));

    a_r9_nostore: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[NOSTORE_W-1:0] == '0);
endmodule

// File: rtl/sdh_irq_status_unit.sv
// Module: top of the SD host interrupt status unit. It decodes the
// register port, merges the event sources and muxes read data.
// Reads have no side effects. Assumes one access per cycle.
module sdh_irq_status_unit
    import sdh_irq_pkg::*;
#(
    parameter int unsigned DMA_W1C_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic [SEL_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [REG_W-1:0] stat_set,
    input  logic             card_insert,
    input  logic             card_remove,
    input  logic [REG_W-1:0] dma_set,
    output logic             irq_o
);
    logic wr_ctrl, wr_mask, wr_raw_clr, wr_card, wr_dma;
    logic [REG_W-1:0] raw_q, ctrl_q, mask_q, masked, card_q, dma_q;
    logic [REG_W-1:0] card_raw_set, card_raw_clr, sw_clr;

    // Write decode. The masked and raw selects share the clear path.
    always_comb begin
        wr_ctrl    = reg_wr_en && (reg_addr == SEL_CTRL);
        wr_mask    = reg_wr_en && (reg_addr == SEL_MASK);
        wr_raw_clr = reg_wr_en && ((reg_addr == SEL_MASKED) || (reg_addr == SEL_RAW));
        wr_card    = reg_wr_en && (reg_addr == SEL_CARD);
        wr_dma     = reg_wr_en && (reg_addr == SEL_DMA);
        sw_clr     = wr_raw_clr ? reg_wdata : '0;
    end

    sdh_card_dma_status #(.DMA_W1C_W(DMA_W1C_W)) card_dma_i (
        .clk(clk), .rst_n(rst_n),
        .card_insert(card_insert), .card_remove(card_remove),
        .wr_card(wr_card), .wr_dma(wr_dma), .wdata(reg_wdata),
        .dma_set(dma_set), .card_q(card_q), .dma_q(dma_q),
        .raw_set(card_raw_set), .raw_clr(card_raw_clr)
    );

    sdh_raw_status #(.W(REG_W)) raw_i (
        .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr),
        .hw_set(stat_set | card_raw_set), .hw_clr(card_raw_clr),
        .raw_q(raw_q)
    );

    sdh_irq_gate gate_i (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
        .wdata(reg_wdata), .raw_i(raw_q), .ctrl_q(ctrl_q), .mask_q(mask_q),
        .masked_o(masked), .irq_o(irq_o)
    );

    // Read mux. Unmapped selects and idle cycles return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd_en) begin
            case (reg_addr)
                SEL_CTRL:   reg_rdata = ctrl_q;
                SEL_MASK:   reg_rdata = mask_q;
                SEL_MASKED: reg_rdata = masked;
                SEL_RAW:    reg_rdata = raw_q;
                SEL_CARD:   reg_rdata = card_q;
                SEL_DMA:    reg_rdata = dma_q;
                default:    reg_rdata = '0;
            endcase
        end
    end

    // R11: with no read strobe the bus stays quiet.
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |-> (reg_rdata == '0));
endmodule

// File: tb/sdh_irq_status_unit_tb_top.sv
// Bench: directed corner cases, then seeded random traffic. Every
// cycle is checked against a reference model kept in the bench.
module sdh_irq_status_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, stat_set = '0, dma_set = '0;
    logic        card_insert = 1'b0, card_remove = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int checks = 0, fails = 0, cycles = 0;
    logic [31:0] m_ctrl, m_mask, m_raw, m_card, m_dma;
    logic        m_irq;

    always #5 clk = ~clk;

    sdh_irq_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stat_set(stat_set), .card_insert(card_insert), .card_remove(card_remove),
        .dma_set(dma_set), .irq_o(irq_o)
    );

    function automatic logic [31:0] model_read(input bit rd, input logic [2:0] a);
        if (!rd) return 32'h0;
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_mask;
            3'd2: return m_raw & m_mask;
            3'd3: return m_raw;
            3'd4: return m_card;
            3'd5: return m_dma;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input bit rd, input logic [2:0] a);
        if (!rd) return "R11";
        case (a)
            3'd0: return "R9";
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3: return "R4";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 32'h300; m_mask = 0; m_raw = 0; m_card = 32'h100; m_dma = 0; m_irq = 0;
    endtask

    // One bus cycle: drive, check pre-edge state, then advance the model.
    task automatic cyc(input bit wr, input logic [2:0] a, input logic [31:0] wd,
                       input bit rd, input logic [31:0] ev, input bit ins,
                       input bit rem, input logic [31:0] dev, input string tag);
        logic [31:0] clr, hset, hclr;
        bit insx;
        @(negedge clk);
        reg_wr_en = wr; reg_addr = a; reg_wdata = wd; reg_rd_en = rd;
        stat_set = ev; card_insert = ins; card_remove = rem; dma_set = dev;
        #1;
        check((tag == "") ? tag_of(rd, a) : tag, reg_rdata, model_read(rd, a));
        check("R3", {31'b0, irq_o}, {31'b0, m_irq});
        @(posedge clk);
        insx = ins && !rem;
        clr  = (wr && (a == 3'd2 || a == 3'd3)) ? wd : 32'h0;
        hset = ev | (insx ? 32'h4000_0000 : 0) | (rem ? 32'h8000_0000 : 0);
        hclr = (rem ? 32'h4000_0000 : 0) | (insx ? 32'h8000_0000 : 0);
        m_irq = m_ctrl[4] && |(m_raw & m_mask);
        m_raw = (m_raw & ~clr & ~hclr) | hset;
        if (wr && a == 3'd4) m_card = m_card & ~wd;
        if (rem) m_card[8] = 1'b0; else if (insx) m_card[8] = 1'b1;
        m_dma = (m_dma & ~((wr && a == 3'd5) ? (wd & 32'h3FF) : 32'h0)) | dev;
        if (wr && a == 3'd0) m_ctrl = wd & 32'hFFFF_FFF8;
        if (wr && a == 3'd1) m_mask = wd;
    endtask

    task automatic rd_only(input logic [2:0] a, input string tag);
        cyc(0, a, 32'h0, 1, 32'h0, 0, 0, 32'h0, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset values on every select.
        for (int i = 0; i < 6; i++) rd_only(3'(i), "R1");
        check("R1", reg_rdata, 32'h0);
        // R9: reset-control bits never stored.
        cyc(1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "");
        rd_only(3'd0, "R9");
        check("R9", m_ctrl, 32'hFFFF_FFF8);
        cyc(1, 3'd1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "");
        // R5 insertion.
        cyc(0, 3'd0, 0, 0, 0, 1, 0, 0, "");
        rd_only(3'd3, "R5");
        rd_only(3'd4, "R5");
        rd_only(3'd2, "R2");
        // R6 removal, then simultaneous pulses.
        cyc(0, 3'd0, 0, 0, 0, 0, 1, 0, "");
        rd_only(3'd3, "R6");
        rd_only(3'd4, "R6");
        cyc(0, 3'd0, 0, 0, 0, 1, 1, 0, "");
        rd_only(3'd3, "R6");
        // R10: set and clear of bit 5 in one cycle; bit 8 of card too.
        cyc(1, 3'd3, 32'hFFFF_FFFF, 0, 32'h20, 0, 0, 0, "");
        rd_only(3'd3, "R10");
        cyc(1, 3'd4, 32'h100, 0, 0, 1, 0, 0, "");
        rd_only(3'd4, "R10");
        // R4 via the masked select.
        cyc(1, 3'd2, 32'h20, 0, 0, 0, 0, 0, "");
        rd_only(3'd3, "R4");
        // R7 card status clear.
        cyc(1, 3'd4, 32'h100, 0, 0, 0, 0, 0, "");
        rd_only(3'd4, "R7");
        // R8 DMA partial clear and set-wins.
        cyc(0, 3'd0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, "");
        cyc(1, 3'd5, 32'hFFFF_FFFF, 0, 0, 0, 0, 32'h1, "");
        rd_only(3'd5, "R8");
        check("R8", m_dma, 32'hFFFF_FC01);
        // R3: disabling the global enable drops the line.
        cyc(0, 3'd0, 0, 0, 32'h1, 0, 0, 0, "");
        rd_only(3'd1, "R3");
        cyc(1, 3'd0, 32'h0, 0, 0, 0, 0, 0, "");
        rd_only(3'd0, "R3");
        rd_only(3'd0, "R3");
        // R11 unmapped selects.
        cyc(1, 3'd6, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, "R11");
        cyc(1, 3'd7, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, "R11");
        for (int i = 0; i < 6; i++) rd_only(3'(i), "R11");
        // Random traffic.
        for (int n = 0; n < 4000; n++) begin
            bit wr, rd, ins, rem;
            logic [2:0] a;
            logic [31:0] wd;
            wr  = ($urandom % 10) < 3;
            rd  = ($urandom % 10) < 9;
            a   = 3'($urandom % 8);
            wd  = $urandom;
            if (a == 3'd0 && ($urandom % 2) == 1) wd[4] = 1'b1;
            ins = ($urandom % 20) == 0;
            rem = ($urandom % 20) == 0;
            cyc(wr, a, wd, rd, $urandom & $urandom & $urandom, ins, rem,
                $urandom & $urandom & $urandom & $urandom, "");
        end
        finish_run();
    end
endmodule